// File: doc/BRIEF.md
# Paged Address Mapper with Per-Page Wait Generation

This block sits between a 16-bit processor and its external memory system. It splits the 64 KB logical space into eight windows of 8 KB. The upper three logical address bits pick a window, and each window has an 8-bit page register. The physical address is that page number with the 13-bit window offset appended, which makes it 21 bits wide. The page number also sets the speed of each access. A block of four fast pages needs no wait cycles. Every other page costs one. A global extra-wait enable and a per-access video strobe can each lengthen the stall.

The processor writes page registers one at a time through a small write port. A speed-load strobe writes a whole preset in one cycle. Each of the five speed levels differs only in the pages given to window 0 and window 4, and in the state of the extra-wait enable. A ROM-select level replaces the page of window 2 with a peripheral-card page while it is held, and leaves the stored register untouched. Logical addresses from 0xF000 upward belong to the processor's on-chip RAM and never stall.

Stalls are produced by a two-state machine. `ST_IDLE` watches for the access strobe. If the access needs no wait, the machine stays in `ST_IDLE` and ready stays high. If it needs exactly one wait, ready drops for that cycle only and the machine stays in `ST_IDLE`. If it needs two or more, the machine moves to `ST_WAIT` and loads a down-counter. `ST_WAIT` holds ready low and returns to `ST_IDLE` in the cycle the counter has reached zero.

Top module: `page_mapper_top`

## Requirements
- R1: Synchronous reset loads windows 0..7 with 0xEC, 0xED, 0x07, 0x34, 0xEE, 0xEF, 0x03, 0x53. It also clears the extra-wait enable.
- R2: `phys_addr` equals {page register of window `log_addr[15:13]`, `log_addr[12:0]`}.
- R3: An external access to pages 0xEC through 0xEF has a base wait of zero. An external access to any other page has a base wait of one.
- R4: When `log_addr` >= 0xF000, `int_hit` is 1 and the access produces no wait cycle. This holds whatever window 7 holds and whatever the video strobe and extra-wait settings are.
- R5: While the extra-wait enable is set, each external access gets one more wait cycle.
- R6: An external access with `video_acc` high gets VID_WS more wait cycles (default 4), at every speed level.
- R7: `ready` goes low in the cycle in which `acc_valid` is high and stays low for exactly the total wait count. An access with a total of zero keeps `ready` high.
- R8: When `reg_we` is high, `reg_wdata` is written into window `reg_idx`, and the new value is used from the next clock onward.
- R9: `speed_ld` with a `speed_code` of 1 to 5 sets window 0 / window 4 / extra-wait to the following values: 1 → EC/34/on, 2 → 33/34/off, 3 → EC/34/off, 4 → 33/EE/off, 5 → EC/EE/off. Codes 0, 6 and 7 change nothing.
- R10: While `rom_sel` is high, accesses to window 2 use page 0xBA. When `rom_sel` goes low, the stored window 2 value is used again.
- R11: A valid speed load and a register write in the same cycle: the preset wins for windows 0 and 4, and a write to any other window still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Page register write strobe |
| reg_idx | input | 3 | Window index to write |
| reg_wdata | input | 8 | Page value to write |
| speed_ld | input | 1 | Speed preset load strobe |
| speed_code | input | 3 | Speed level 1..5 |
| rom_sel | input | 1 | Forces window 2 to the peripheral page |
| acc_valid | input | 1 | One-cycle strobe at the start of an access |
| log_addr | input | 16 | Logical address |
| video_acc | input | 1 | Access targets video, adds video waits |
| phys_addr | output | 21 | Mapped physical address |
| int_hit | output | 1 | Address lies in on-chip RAM |
| ready | output | 1 | Low while the access is stalled |

## Verification
Two functions can land on the same clock edge: a register write and a speed-preset load. The bench asserts both in the same cycle twice. In the first case the write targets window 0, which the preset also sets. In the second case the write targets window 6, which the preset leaves alone. The outcome is judged by the physical address and the wait count of accesses that follow. The preset value must appear in window 0, and the written value must appear in window 6. The ROM override is also combined with a write to window 2, to show that the override masks the stored value without discarding it.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

    localparam int LOG_W    = 16;
    localparam int NWIN     = 8;
    localparam int PAGE_W   = 8;
    localparam int WIN_BITS = $clog2(NWIN);
    localparam int OFF_W    = LOG_W - WIN_BITS;
    localparam int PHYS_W   = PAGE_W + OFF_W;

    // windows touched by the speed presets
    localparam int LO_WIN = 0;
    localparam int HI_WIN = 4;

    typedef logic [NWIN-1:0][PAGE_W-1:0] pages_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wst_e;

    typedef struct packed {
        logic              ok;
        logic [PAGE_W-1:0] lo_page;
        logic [PAGE_W-1:0] hi_page;
        logic              extra;
    } preset_t;

    function automatic logic [PAGE_W-1:0] boot_page(int idx);
        case (idx)
            0:       return 8'hEC;
            1:       return 8'hED;
            2:       return 8'h07;
            3:       return 8'h34;
            4:       return 8'hEE;
            5:       return 8'hEF;
            6:       return 8'h03;
            default: return 8'h53;
        endcase
    endfunction

    function automatic preset_t speed_preset(logic [2:0] code);
        preset_t p;
        p = '0;
        case (code)
            3'd1: p = '{ok: 1'b1, lo_page: 8'hEC, hi_page: 8'h34, extra: 1'b1};
            3'd2: p = '{ok: 1'b1, lo_page: 8'h33, hi_page: 8'h34, extra: 1'b0};
            3'd3: p = '{ok: 1'b1, lo_page: 8'hEC, hi_page: 8'h34, extra: 1'b0};
            3'd4: p = '{ok: 1'b1, lo_page: 8'h33, hi_page: 8'hEE, extra: 1'b0};
            3'd5: p = '{ok: 1'b1, lo_page: 8'hEC, hi_page: 8'hEE, extra: 1'b0};
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmap_pages.sv
module pmap_pages
    import pmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [WIN_BITS-1:0] reg_idx,
    input  logic [PAGE_W-1:0]   reg_wdata,
    input  logic                speed_ld,
    input  logic [2:0]          speed_code,
    output pages_t              pages,
    output logic                extra_en
);

    preset_t ps;
    logic    ps_take;

    always_comb begin
        ps      = speed_preset(speed_code);
        ps_take = speed_ld && ps.ok;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [PAGE_W-1:0] RST_VAL = boot_page(g);
        localparam bit IS_LO = (g == LO_WIN);
        localparam bit IS_HI = (g == HI_WIN);

        logic [PAGE_W-1:0] page_r;
        logic              preset_hit;
        logic              write_hit;
        logic [PAGE_W-1:0] preset_val;

        always_comb begin
            preset_hit = ps_take && (IS_LO || IS_HI);
            write_hit  = reg_we && (reg_idx == WIN_BITS'(g));
            preset_val = IS_LO ? ps.lo_page : ps.hi_page;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                page_r <= RST_VAL;
            end else if (preset_hit) begin
                page_r <= preset_val;
            end else if (write_hit) begin
                page_r <= reg_wdata;
            end
        end

        assign pages[g] = page_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            extra_en <= 1'b0;
        end else if (ps_take) begin
            extra_en <= ps.extra;
        end
    end

endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
    import pmap_pkg::*;
#(
    parameter int                VID_WS    = 4,
    parameter int                WW        = 3,
    parameter logic [LOG_W-1:0]  INT_BASE  = 16'hF000,
    parameter logic [PAGE_W-1:0] ROM_PAGE  = 8'hBA,
    parameter int                ROM_WIN   = 2,
    parameter logic [PAGE_W-1:0] FAST_BASE = 8'hEC
)(
    input  pages_t            pages,
    input  logic              extra_en,
    input  logic              rom_sel,
    input  logic [LOG_W-1:0]  log_addr,
    input  logic              video_acc,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              int_hit,
    output logic [WW-1:0]     wait_total
);

    logic [WIN_BITS-1:0] win;
    logic [PAGE_W-1:0]   page;
    logic                fast;

    always_comb begin
        win = log_addr[LOG_W-1:OFF_W];
        if (rom_sel && (win == WIN_BITS'(ROM_WIN))) begin
            page = ROM_PAGE;
        end else begin
            page = pages[win];
        end
        phys_addr = {page, log_addr[OFF_W-1:0]};
        int_hit   = (log_addr >= INT_BASE);
        // the fast block is four consecutive pages aligned to four
        fast      = (page[PAGE_W-1:2] == FAST_BASE[PAGE_W-1:2]);

        wait_total = '0;
        if (!int_hit) begin
            if (!fast) begin
                wait_total = wait_total + WW'(1);
            end
            if (extra_en) begin
                wait_total = wait_total + WW'(1);
            end
            if (video_acc) begin
                wait_total = wait_total + WW'(VID_WS);
            end
        end
    end

endmodule

// File: rtl/pmap_wait_fsm.sv
module pmap_wait_fsm
    import pmap_pkg::*;
#(
    parameter int WW = 3
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [WW-1:0] wait_total,
    output logic          ready,
    output logic          busy
);

    wst_e          state_q;
    wst_e          state_d;
    logic [WW-1:0] cnt_q;
    logic          start_long;

    assign start_long = acc_valid && (wait_total > WW'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_long)        state_d = ST_WAIT;
            ST_WAIT: if (cnt_q == '0)       state_d = ST_IDLE;
        endcase
    end

    // state register and down-counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_long) begin
                cnt_q <= wait_total - WW'(2);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - WW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        ready = 1'b1;
        busy  = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = !(acc_valid && (wait_total != '0));
            ST_WAIT: begin
                ready = 1'b0;
                busy  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/page_mapper_top.sv
module page_mapper_top
    import pmap_pkg::*;
#(
    parameter int                VID_WS   = 4,
    parameter logic [LOG_W-1:0]  INT_BASE = 16'hF000,
    parameter logic [PAGE_W-1:0] ROM_PAGE = 8'hBA,
    parameter int                ROM_WIN  = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_idx,
    input  logic [7:0]        reg_wdata,
    input  logic              speed_ld,
    input  logic [2:0]        speed_code,
    input  logic              rom_sel,
    input  logic              acc_valid,
    input  logic [15:0]       log_addr,
    input  logic              video_acc,
    output logic [20:0]       phys_addr,
    output logic              int_hit,
    output logic              ready
);

    localparam int WW = $clog2(VID_WS + 3);

    pages_t        win_pages;
    logic          extra_en;
    logic [WW-1:0] wait_total;
    logic          fsm_busy;

    pmap_pages u_pages (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .speed_ld   (speed_ld),
        .speed_code (speed_code),
        .pages      (win_pages),
        .extra_en   (extra_en)
    );

    pmap_xlate #(
        .VID_WS   (VID_WS),
        .WW       (WW),
        .INT_BASE (INT_BASE),
        .ROM_PAGE (ROM_PAGE),
        .ROM_WIN  (ROM_WIN)
    ) u_xlate (
        .pages      (win_pages),
        .extra_en   (extra_en),
        .rom_sel    (rom_sel),
        .log_addr   (log_addr),
        .video_acc  (video_acc),
        .phys_addr  (phys_addr),
        .int_hit    (int_hit),
        .wait_total (wait_total)
    );

    pmap_wait_fsm #(
        .WW (WW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .wait_total (wait_total),
        .ready      (ready),
        .busy       (fsm_busy)
    );

endmodule

// File: rtl/pmap_checker.sv
module pmap_checker
    import pmap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [2:0]  reg_idx,
    input logic [7:0]  reg_wdata,
    input logic        speed_ld,
    input logic [2:0]  speed_code,
    input logic        rom_sel,
    input logic        acc_valid,
    input logic [15:0] log_addr,
    input logic [20:0] phys_addr,
    input logic        int_hit,
    input logic        ready,
    input logic        fsm_busy,
    input pages_t      win_pages
);

    assert_map_page_R2: assert property (@(posedge clk) disable iff (rst)
        !(rom_sel && log_addr[15:13] == 3'd2) |->
            phys_addr[20:13] == win_pages[log_addr[15:13]]);

    assert_internal_nostall_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !fsm_busy && log_addr >= 16'hF000) |-> (ready && int_hit));

    assert_stall_origin_R7: assert property (@(posedge clk) disable iff (rst)
        (!ready && !fsm_busy) |-> (acc_valid && !int_hit));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !speed_ld) |=> win_pages[$past(reg_idx)] == $past(reg_wdata));

    assert_preset_four_R9: assert property (@(posedge clk) disable iff (rst)
        (speed_ld && speed_code == 3'd4) |=>
            (win_pages[0] == 8'h33 && win_pages[4] == 8'hEE));

    assert_rom_force_R10: assert property (@(posedge clk) disable iff (rst)
        (rom_sel && log_addr[15:13] == 3'd2) |-> phys_addr[20:13] == 8'hBA);

endmodule

bind page_mapper_top pmap_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .speed_ld   (speed_ld),
    .speed_code (speed_code),
    .rom_sel    (rom_sel),
    .acc_valid  (acc_valid),
    .log_addr   (log_addr),
    .phys_addr  (phys_addr),
    .int_hit    (int_hit),
    .ready      (ready),
    .fsm_busy   (fsm_busy),
    .win_pages  (win_pages)
);

// File: tb/page_mapper_top_tb.sv
`timescale 1ns/1ps
module page_mapper_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        speed_ld = 1'b0;
    logic [2:0]  speed_code = '0;
    logic        rom_sel = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] log_addr = '0;
    logic        video_acc = 1'b0;
    logic [20:0] phys_addr;
    logic        int_hit;
    logic        ready;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    page_mapper_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .speed_ld(speed_ld), .speed_code(speed_code),
        .rom_sel(rom_sel), .acc_valid(acc_valid), .log_addr(log_addr),
        .video_acc(video_acc), .phys_addr(phys_addr), .int_hit(int_hit),
        .ready(ready)
    );

    // reference state
    logic [7:0] m_page [8];
    bit         m_extra;
    bit         m_rom;

    typedef struct {
        logic [20:0] phys;
        bit          ihit;
        int          waits;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(bit ok, string tag, string what, int got, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    function automatic void model_reset();
        m_page[0] = 8'hEC; m_page[1] = 8'hED; m_page[2] = 8'h07; m_page[3] = 8'h34;
        m_page[4] = 8'hEE; m_page[5] = 8'hEF; m_page[6] = 8'h03; m_page[7] = 8'h53;
        m_extra = 0;
        m_rom   = 0;
    endfunction

    function automatic bit model_preset(logic [2:0] c);
        case (c)
            3'd1: begin m_page[0] = 8'hEC; m_page[4] = 8'h34; m_extra = 1; end
            3'd2: begin m_page[0] = 8'h33; m_page[4] = 8'h34; m_extra = 0; end
            3'd3: begin m_page[0] = 8'hEC; m_page[4] = 8'h34; m_extra = 0; end
            3'd4: begin m_page[0] = 8'h33; m_page[4] = 8'hEE; m_extra = 0; end
            3'd5: begin m_page[0] = 8'hEC; m_page[4] = 8'hEE; m_extra = 0; end
            default: return 0;
        endcase
        return 1;
    endfunction

    function automatic logic [7:0] model_page(logic [15:0] a);
        if (m_rom && a[15:13] == 3'd2) return 8'hBA;
        return m_page[a[15:13]];
    endfunction

    function automatic int model_waits(logic [15:0] a, bit vid);
        logic [7:0] p;
        int w;
        if (a >= 16'hF000) return 0;
        p = model_page(a);
        w = (p >= 8'hEC && p <= 8'hEF) ? 0 : 1;
        if (m_extra) w++;
        if (vid) w += 4;
        return w;
    endfunction

    // driver tasks
    task automatic write_reg(logic [2:0] idx, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        m_page[idx] = d;
    endtask

    task automatic load_speed(logic [2:0] c);
        @(negedge clk);
        speed_ld = 1; speed_code = c;
        @(negedge clk);
        speed_ld = 0;
        void'(model_preset(c));
    endtask

    task automatic load_and_write(logic [2:0] c, logic [2:0] idx, logic [7:0] d);
        logic [7:0] keep0, keep4;
        @(negedge clk);
        speed_ld = 1; speed_code = c; reg_we = 1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        speed_ld = 0; reg_we = 0;
        m_page[idx] = d;
        void'(model_preset(c));
    endtask

    task automatic set_rom(bit v);
        @(negedge clk);
        rom_sel = v;
        m_rom = v;
    endtask

    task automatic access(logic [15:0] a, bit vid, string tag);
        exp_t e;
        int w;
        w = model_waits(a, vid);
        e.phys  = {model_page(a), a[12:0]};
        e.ihit  = (a >= 16'hF000);
        e.waits = w;
        e.tag   = tag;
        @(negedge clk);
        exp_q.push_back(e);
        log_addr = a; video_acc = vid; acc_valid = 1;
        @(negedge clk);
        acc_valid = 0;
        repeat (w + 1) @(negedge clk);
    endtask

    // monitor
    initial begin
        exp_t cur;
        bit   counting = 0;
        int   lows = 0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                if (counting) begin
                    if (!ready) lows++;
                    else begin
                        check(lows == cur.waits, cur.tag, "R7 wait cycles", lows, cur.waits);
                        counting = 0;
                    end
                end
                if (acc_valid) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R7", "unexpected access", 0, 1);
                    end else begin
                        cur = exp_q.pop_front();
                        check(phys_addr == cur.phys, cur.tag, "R2 phys_addr",
                              int'(phys_addr), int'(cur.phys));
                        check(int_hit == cur.ihit, cur.tag, "R4 int_hit",
                              int'(int_hit), int'(cur.ihit));
                        if (ready) begin
                            check(cur.waits == 0, cur.tag, "R7 wait cycles", 0, cur.waits);
                        end else begin
                            counting = 1;
                            lows = 1;
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #2;
        check(ready == 1'b1, "R7", "idle ready", int'(ready), 1);

        // R1 / R3: reset map, one access per window
        for (int w = 0; w < 7; w++) access(16'(w * 16'h2000 + 16'h0123), 0, "R1");
        access(16'hE456, 0, "R3");

        // R4: on-chip RAM never stalls
        access(16'hF000, 0, "R4");
        access(16'hF800, 1, "R4");

        // R6: video strobe on slow and fast pages
        access(16'h6010, 1, "R6");
        access(16'h8010, 1, "R6");

        // R8: write takes effect on next clock
        write_reg(3'd3, 8'hEE);
        access(16'h6000, 0, "R8");
        write_reg(3'd7, 8'hEC);
        access(16'hE000, 0, "R8");
        access(16'hF002, 0, "R4");

        // R9 / R5: all five speed levels
        load_speed(3'd1);
        access(16'h0100, 0, "R9");
        access(16'h8100, 0, "R5");
        access(16'hA000, 1, "R5");
        access(16'hF100, 1, "R4");
        load_speed(3'd2);
        access(16'h0200, 0, "R9");
        access(16'h8200, 0, "R9");
        load_speed(3'd3);
        access(16'h0300, 0, "R9");
        load_speed(3'd4);
        access(16'h0400, 0, "R9");
        access(16'h8400, 0, "R9");
        load_speed(3'd5);
        access(16'h0500, 0, "R9");
        access(16'h8500, 1, "R9");

        // R9: invalid codes change nothing
        load_speed(3'd0);
        load_speed(3'd6);
        load_speed(3'd7);
        access(16'h0600, 0, "R9");
        access(16'h8600, 0, "R9");

        // R10: ROM override masks and preserves window 2
        set_rom(1);
        access(16'h4321, 0, "R10");
        write_reg(3'd2, 8'hED);
        access(16'h4000, 0, "R10");
        set_rom(0);
        access(16'h4000, 0, "R10");

        // R11: simultaneous preset and write
        load_and_write(3'd4, 3'd0, 8'h11);
        access(16'h0010, 0, "R11");
        load_and_write(3'd2, 3'd6, 8'hEE);
        access(16'hC010, 0, "R11");
        access(16'h0020, 0, "R11");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7", "pending accesses", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule